// File: doc/BRIEF.md
# Status Word Write Controller

This block owns a 16-bit processor status word together with two shadow copies: one captured on a break or interrupt, one captured on a debug trap. Each of the three can be written through one shared write port. The port carries a per-bit keep mask and a flag that says whether the write comes from hardware or from a software move-to-control-register instruction. Software writes pass through a narrow writable-bit filter. Hardware writes use a wider filter that also reaches the debug-mode bit. Bits outside the selected filter always store zero.

The status word carries a stack-mode bit, and two banked stack pointers sit behind it. A write to the status word that does not keep the stack-mode bit saves the live stack pointer into the bank slot of the old mode. If the mode actually changes, the write also loads the stack pointer from the slot of the new mode. A debug-trap input runs the trap entry sequence in one cycle. It saves the return PC and the full status word. The status word then becomes debug mode with only the three flag bits kept, and a one-cycle request to jump to the debug vector is raised.

Top module: `swc_stat_ctrl`

## Requirements
- R1: A software write (`wr_hw`=0) can only store ones at bits 15 (stack mode), 13, 12, 10, 9, 8, 3 (flag F0), 2 (flag F1) and 0 (carry), which is the filter value 0xB70D. Every other bit of the target register stores 0.
- R2: A software write can never set bit 11 (debug mode). If that bit is not kept, it is cleared.
- R3: A hardware write (`wr_hw`=1) uses the filter 0xBF0D, which is the software filter plus bit 11.
- R4: A bit whose `wr_keep` bit is 1 keeps its stored value. A bit whose keep bit is 0 takes the filtered new value. The result is visible at the register output after the next clock edge.
- R5: A status-word write with `wr_keep[15]`=0 stores `sp_in` into the held slot indexed by the old stack-mode bit. If the new stack-mode bit differs from the old one, then on the next edge `sp_out` takes the prior content of the new mode's held slot and `sp_load` pulses for one cycle. In every other case `sp_load` is 0.
- R6: `wr_sel` picks the target register: 0 is the status word, 1 is the break shadow, 2 is the debug shadow, 3 writes nothing. The shadows use the same filters as the status word and never touch the stack pointers.
- R7: On `trap_en`, the status word becomes 0x0800 ORed with its prior bits 3, 2 and 0. `vec_jump` is 1 for exactly the following cycle. This update counts as a hardware status write with no bits kept, so R5 applies to it.
- R8: On `trap_en`, `dbg_pc` becomes `pc_in`+1 modulo 2^16 and the debug shadow receives the full prior status word.
- R9: Synchronous reset clears all three registers, both held stack pointers, `sp_out`, `sp_load`, `dbg_pc` and `vec_jump`.
- R10: When `trap_en` and `wr_en` are high in the same cycle, the trap is performed and the software or hardware write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_sel | input | 2 | Target: 0 status, 1 break shadow, 2 debug shadow, 3 none |
| wr_hw | input | 1 | 1 for a hardware-originated write |
| wr_keep | input | 16 | Per-bit keep mask, 1 keeps the stored bit |
| wr_data | input | 16 | New value |
| trap_en | input | 1 | Debug trap entry |
| pc_in | input | 16 | PC of the trapping instruction |
| sp_in | input | 16 | Live stack pointer from the register file |
| stat_word | output | 16 | Current status word |
| brk_shadow | output | 16 | Break/interrupt status copy |
| dbg_shadow | output | 16 | Debug-trap status copy |
| held_sp0 | output | 16 | Held stack pointer for stack mode 0 |
| held_sp1 | output | 16 | Held stack pointer for stack mode 1 |
| sp_out | output | 16 | Stack pointer value to load into the register file |
| sp_load | output | 1 | One-cycle load request for `sp_out` |
| dbg_pc | output | 16 | Saved debug return PC |
| vec_jump | output | 1 | One-cycle request to jump to the debug vector |

## Verification
The assertions check several properties on every cycle. Kept bits hold their value, and a software write never raises the debug-mode bit. A mode-changing status write always produces the stack-pointer load with the old bank value. The trap always yields the debug-mode status, the full-status debug copy, the incremented PC and the vector pulse. A trap also suppresses a concurrent shadow write. The bench scenarios cover what a property cannot see as a whole. That includes the absolute filter values 0xB70D and 0xBF0D, the exact contents of both held slots after a chain of mode flips, the PC wrap at 0xFFFF, the reset state, and the no-op of select value 3.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;
  localparam int WORD_W = 16;
  // bit positions in the status word
  localparam int POS_SM = 15;
  localparam int POS_EA = 13;
  localparam int POS_DB = 12;
  localparam int POS_DM = 11;
  localparam int POS_IE = 10;
  localparam int POS_RP = 9;
  localparam int POS_MD = 8;
  localparam int POS_F0 = 3;
  localparam int POS_F1 = 2;
  localparam int POS_CY = 0;
  localparam int N_REGS = 3;

  localparam logic [WORD_W-1:0] FLAG_BITS =
    (WORD_W'(1) << POS_F0) | (WORD_W'(1) << POS_F1) | (WORD_W'(1) << POS_CY);
  localparam logic [WORD_W-1:0] SW_FILTER =
    (WORD_W'(1) << POS_SM) | (WORD_W'(1) << POS_EA) | (WORD_W'(1) << POS_DB) |
    (WORD_W'(1) << POS_IE) | (WORD_W'(1) << POS_RP) | (WORD_W'(1) << POS_MD) |
    FLAG_BITS;
  localparam logic [WORD_W-1:0] HW_FILTER = SW_FILTER | (WORD_W'(1) << POS_DM);
  localparam logic [WORD_W-1:0] DM_BIT    = WORD_W'(1) << POS_DM;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_BRK  = 2'd1,
    SEL_DBG  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/swc_stat_reg.sv
`timescale 1ns/1ps
module swc_stat_reg #(
  parameter int W = swc_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         hw,
  input  logic [W-1:0] keep,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] SWF = W'(swc_pkg::SW_FILTER);
  localparam logic [W-1:0] HWF = W'(swc_pkg::HW_FILTER);
  localparam int DMP = swc_pkg::POS_DM;

  logic [W-1:0] filt;
  logic [W-1:0] nxt;

  always_comb begin
    filt = hw ? HWF : SWF;
    nxt  = (q & keep) | (data & filt & ~keep);
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= nxt;
  end

  AST_KEPT_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
    en |=> ((q & $past(keep)) == ($past(q) & $past(keep)))); // R4
  AST_SW_NO_DM_SET: assert property (@(posedge clk) disable iff (rst)
    (en && !hw && !q[DMP]) |=> !q[DMP]); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q)); // R6
endmodule

// File: rtl/swc_sp_bank.sv
`timescale 1ns/1ps
module swc_sp_bank #(
  parameter int W = swc_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic         old_sm,
  input  logic         new_sm,
  input  logic [W-1:0] sp_in,
  output logic [W-1:0] held0,
  output logic [W-1:0] held1,
  output logic [W-1:0] sp_out,
  output logic         sp_load
);
  localparam int SLOTS = 2;

  logic [W-1:0] bank [SLOTS];
  logic         swap;

  assign swap  = upd && (old_sm != new_sm);
  assign held0 = bank[0];
  assign held1 = bank[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) bank[i] <= '0;
      sp_out  <= '0;
      sp_load <= 1'b0;
    end else begin
      sp_load <= 1'b0;
      if (upd) bank[old_sm] <= sp_in;
      if (swap) begin
        sp_out  <= bank[new_sm];
        sp_load <= 1'b1;
      end
    end
  end

  AST_SWAP_LOADS_BANK: assert property (@(posedge clk) disable iff (rst)
    swap |=> (sp_load && sp_out == $past(new_sm ? held1 : held0))); // R5
  AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (rst)
    !swap |=> !sp_load); // R5
endmodule

// File: rtl/swc_trap_seq.sv
`timescale 1ns/1ps
module swc_trap_seq #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_en,
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] dbg_pc,
  output logic            vec_jump
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_pc   <= '0;
      vec_jump <= 1'b0;
    end else begin
      vec_jump <= trap_en;
      if (trap_en) dbg_pc <= pc_in + PC_W'(1);
    end
  end

  AST_TRAP_PC_SAVE: assert property (@(posedge clk) disable iff (rst)
    trap_en |=> (vec_jump && dbg_pc == PC_W'($past(pc_in) + PC_W'(1)))); // R8
  AST_VEC_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    !trap_en |=> !vec_jump); // R7
endmodule

// File: rtl/swc_stat_ctrl.sv
`timescale 1ns/1ps
module swc_stat_ctrl #(
  parameter int W    = swc_pkg::WORD_W,
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic            wr_hw,
  input  logic [W-1:0]    wr_keep,
  input  logic [W-1:0]    wr_data,
  input  logic            trap_en,
  input  logic [PC_W-1:0] pc_in,
  input  logic [W-1:0]    sp_in,
  output logic [W-1:0]    stat_word,
  output logic [W-1:0]    brk_shadow,
  output logic [W-1:0]    dbg_shadow,
  output logic [W-1:0]    held_sp0,
  output logic [W-1:0]    held_sp1,
  output logic [W-1:0]    sp_out,
  output logic            sp_load,
  output logic [PC_W-1:0] dbg_pc,
  output logic            vec_jump
);
  import swc_pkg::*;

  localparam int NR = N_REGS;
  localparam logic [W-1:0] FLAGS = W'(FLAG_BITS);
  localparam logic [W-1:0] DMW   = W'(DM_BIT);

  logic [NR-1:0]        r_en;
  logic [NR-1:0]        r_hw;
  logic [NR-1:0][W-1:0] r_keep;
  logic [NR-1:0][W-1:0] r_data;
  logic [NR-1:0][W-1:0] r_q;

  // write steering: a trap overrides any port write in the same cycle
  always_comb begin
    for (int i = 0; i < NR; i++) begin
      r_en[i]   = wr_en && !trap_en && (wr_sel == 2'(i));
      r_hw[i]   = wr_hw;
      r_keep[i] = wr_keep;
      r_data[i] = wr_data;
    end
    if (trap_en) begin
      r_en[SEL_STAT]   = 1'b1;
      r_hw[SEL_STAT]   = 1'b1;
      r_keep[SEL_STAT] = '0;
      r_data[SEL_STAT] = DMW | (r_q[SEL_STAT] & FLAGS);
      r_en[SEL_DBG]    = 1'b1;
      r_hw[SEL_DBG]    = 1'b1;
      r_keep[SEL_DBG]  = '0;
      r_data[SEL_DBG]  = r_q[SEL_STAT];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NR; g++) begin : g_reg
      swc_stat_reg #(.W(W)) u_reg (
        .clk  (clk),
        .rst  (rst),
        .en   (r_en[g]),
        .hw   (r_hw[g]),
        .keep (r_keep[g]),
        .data (r_data[g]),
        .q    (r_q[g])
      );
    end
  endgenerate

  assign stat_word  = r_q[SEL_STAT];
  assign brk_shadow = r_q[SEL_BRK];
  assign dbg_shadow = r_q[SEL_DBG];

  logic sm_upd;
  logic sm_old;
  logic sm_new;

  // stack mode is in both filters, so the new mode is the raw data bit
  assign sm_upd = r_en[SEL_STAT] && !r_keep[SEL_STAT][POS_SM];
  assign sm_old = r_q[SEL_STAT][POS_SM];
  assign sm_new = r_data[SEL_STAT][POS_SM];

  swc_sp_bank #(.W(W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .upd     (sm_upd),
    .old_sm  (sm_old),
    .new_sm  (sm_new),
    .sp_in   (sp_in),
    .held0   (held_sp0),
    .held1   (held_sp1),
    .sp_out  (sp_out),
    .sp_load (sp_load)
  );

  swc_trap_seq #(.PC_W(PC_W)) u_trap (
    .clk      (clk),
    .rst      (rst),
    .trap_en  (trap_en),
    .pc_in    (pc_in),
    .dbg_pc   (dbg_pc),
    .vec_jump (vec_jump)
  );

  AST_TRAP_STATUS: assert property (@(posedge clk) disable iff (rst)
    trap_en |=> (stat_word == (DMW | ($past(stat_word) & FLAGS)))); // R7
  AST_TRAP_DBG_COPY: assert property (@(posedge clk) disable iff (rst)
    trap_en |=> (dbg_shadow == $past(stat_word))); // R8
  AST_TRAP_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (trap_en && wr_en && wr_sel == 2'd1) |=> $stable(brk_shadow)); // R10
  AST_SHADOW_NO_SP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !trap_en && wr_sel != 2'd0) |=> (!sp_load && $stable(held_sp0) && $stable(held_sp1))); // R6
endmodule

// File: tb/test_swc_stat_ctrl.sv
`timescale 1ns/1ps
module test_swc_stat_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic        wr_hw = 1'b0;
  logic [15:0] wr_keep = '0;
  logic [15:0] wr_data = '0;
  logic        trap_en = 1'b0;
  logic [15:0] pc_in = '0;
  logic [15:0] sp_in = '0;
  logic [15:0] stat_word, brk_shadow, dbg_shadow, held_sp0, held_sp1, sp_out, dbg_pc;
  logic        sp_load, vec_jump;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  swc_stat_ctrl i_swc_stat_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_hw(wr_hw),
    .wr_keep(wr_keep), .wr_data(wr_data), .trap_en(trap_en), .pc_in(pc_in),
    .sp_in(sp_in), .stat_word(stat_word), .brk_shadow(brk_shadow),
    .dbg_shadow(dbg_shadow), .held_sp0(held_sp0), .held_sp1(held_sp1),
    .sp_out(sp_out), .sp_load(sp_load), .dbg_pc(dbg_pc), .vec_jump(vec_jump)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one cycle of stimulus at negedge, sample at the next negedge
  task automatic cyc(input logic en, input logic [1:0] sel, input logic hw,
                     input logic [15:0] keep, input logic [15:0] data,
                     input logic trap, input logic [15:0] pc, input logic [15:0] sp);
    @(negedge clk);
    wr_en = en; wr_sel = sel; wr_hw = hw; wr_keep = keep; wr_data = data;
    trap_en = trap; pc_in = pc; sp_in = sp;
    @(negedge clk);
    wr_en = 1'b0; trap_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9", "stat", stat_word, 16'h0000);
    chk("R9", "brk", brk_shadow, 16'h0000);
    chk("R9", "dbg", dbg_shadow, 16'h0000);
    chk("R9", "held0", held_sp0, 16'h0000);
    chk("R9", "held1", held_sp1, 16'h0000);
    chk("R9", "sp_load", 16'(sp_load), 16'h0);
    chk("R9", "dbg_pc", dbg_pc, 16'h0000);
    chk("R9", "vec_jump", 16'(vec_jump), 16'h0);
  endtask

  task automatic t_sw_filter;
    cyc(1, 2'd0, 0, 16'h0000, 16'hFFFF, 0, 0, 16'h1000);
    chk("R1", "sw all ones", stat_word, 16'hB70D);
    chk("R2", "DM blocked", 16'(stat_word[11]), 16'h0);
    chk("R5", "held0 saved", held_sp0, 16'h1000);
    chk("R5", "sp_out from held1", sp_out, 16'h0000);
    chk("R5", "sp_load pulse", 16'(sp_load), 16'h1);
  endtask

  task automatic t_hw_filter;
    cyc(1, 2'd0, 1, 16'h0000, 16'hFFFF, 0, 0, 16'h1111);
    chk("R3", "hw all ones", stat_word, 16'hBF0D);
    chk("R5", "held1 saved same mode", held_sp1, 16'h1111);
    chk("R5", "no load same mode", 16'(sp_load), 16'h0);
  endtask

  task automatic t_keep_mask;
    cyc(1, 2'd0, 0, 16'h00FF, 16'h0000, 0, 0, 16'h2222);
    chk("R4", "keep low byte", stat_word, 16'h000D);
    chk("R5", "held1 saved", held_sp1, 16'h2222);
    chk("R5", "sp_out from held0", sp_out, 16'h1000);
    chk("R5", "sp_load back", 16'(sp_load), 16'h1);
  endtask

  task automatic t_shadows;
    cyc(1, 2'd1, 0, 16'h0000, 16'hFFFF, 0, 0, 16'h7777);
    chk("R6", "break shadow sw", brk_shadow, 16'hB70D);
    chk("R6", "no sp load", 16'(sp_load), 16'h0);
    cyc(1, 2'd2, 1, 16'h0000, 16'hFFFF, 0, 0, 16'h7777);
    chk("R6", "debug shadow hw", dbg_shadow, 16'hBF0D);
    chk("R6", "status untouched", stat_word, 16'h000D);
    chk("R6", "held0 untouched", held_sp0, 16'h1000);
    chk("R6", "held1 untouched", held_sp1, 16'h2222);
    cyc(1, 2'd3, 1, 16'h0000, 16'hFFFF, 0, 0, 16'h7777);
    chk("R6", "sel3 status", stat_word, 16'h000D);
    chk("R6", "sel3 brk", brk_shadow, 16'hB70D);
    chk("R6", "sel3 dbg", dbg_shadow, 16'hBF0D);
  endtask

  task automatic t_sm_kept;
    cyc(1, 2'd0, 0, 16'h8000, 16'h8000, 0, 0, 16'h3333);
    chk("R4", "SM kept rest cleared", stat_word, 16'h0000);
    chk("R5", "held0 unchanged", held_sp0, 16'h1000);
    chk("R5", "held1 unchanged", held_sp1, 16'h2222);
    chk("R5", "no load", 16'(sp_load), 16'h0);
  endtask

  task automatic t_trap;
    cyc(1, 2'd0, 1, 16'h0000, 16'h800D, 0, 0, 16'h4444);
    chk("R5", "setup mode1 load", sp_out, 16'h2222);
    cyc(0, 2'd0, 0, 16'h0000, 16'h0000, 1, 16'h1234, 16'h5555);
    chk("R7", "trap status", stat_word, 16'h080D);
    chk("R7", "vec_jump", 16'(vec_jump), 16'h1);
    chk("R8", "dbg_pc", dbg_pc, 16'h1235);
    chk("R8", "dbg shadow", dbg_shadow, 16'h800D);
    chk("R7", "held1 saved by trap", held_sp1, 16'h5555);
    chk("R7", "sp_out mode0", sp_out, 16'h4444);
    chk("R7", "sp_load by trap", 16'(sp_load), 16'h1);
    @(negedge clk);
    chk("R7", "vec_jump one cycle", 16'(vec_jump), 16'h0);
    chk("R5", "sp_load one cycle", 16'(sp_load), 16'h0);
  endtask

  task automatic t_sw_dm;
    cyc(1, 2'd0, 0, 16'h0000, 16'h0808, 0, 0, 16'h0000);
    chk("R2", "sw cannot set DM", stat_word, 16'h0008);
  endtask

  task automatic t_trap_wins;
    cyc(1, 2'd1, 1, 16'h0000, 16'h0000, 1, 16'hFFFF, 16'h6666);
    chk("R10", "write dropped", brk_shadow, 16'hB70D);
    chk("R10", "trap status", stat_word, 16'h0808);
    chk("R8", "dbg copy", dbg_shadow, 16'h0008);
    chk("R8", "pc wrap", dbg_pc, 16'h0000);
    chk("R7", "held0 saved", held_sp0, 16'h6666);
    chk("R7", "no mode change", 16'(sp_load), 16'h0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sw_filter();
    t_hw_filter();
    t_keep_mask();
    t_shadows();
    t_sm_kept();
    t_trap();
    t_sw_dm();
    t_trap_wins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule